// File: doc/BRIEF.md
# Pipelined 8B/10B Line Encoder

This block turns a stream of bytes into 10-bit line symbols that keep the wire DC-balanced and rich in transitions. Each clock cycle it accepts one byte and a control flag. With the flag low, the byte is coded as a data symbol: its low five bits become a 6-bit sub-block and its high three bits become a 4-bit sub-block. With the flag high, the byte names one of twelve control symbols. These symbols are held in a small store of 11-bit words. The top bit of each word marks a code with equal numbers of ones and zeros.

The path has three register stages. The first captures the inputs. The second does all table lookups in parallel for both the data and the control path. The third holds the running disparity: it picks the polarity of each sub-block, decides on the alternate form of the 3-bit code, selects between the data and the control result, and registers the symbol. After reset the pipeline fills with quiet (all-zero) output, and the running disparity starts negative. From the first cycle after reset is released, every cycle's input is one symbol.

Top module: `sym8b10b_encoder`

## Requirements
- R1: While reset is asserted, and until the first captured input reaches the output, `sym_out` is 0. Reset, including a reset in the middle of a stream, returns the running disparity to negative.
- R2: A byte presented in the cycle before rising edge N appears on `sym_out` right after rising edge N+2. That is three register stages, and a new symbol is produced every cycle.
- R3: Symbol layout: `sym_out[9:4]` is the 6-bit sub-block coded from `byte_in[4:0]`, with its first line bit at bit 9. `sym_out[3:0]` is the 4-bit sub-block coded from `byte_in[7:5]`, with its first line bit at bit 3. With `ctrl_in` low, a byte equal to a control code is still coded as data.
- R4: The 6-bit sub-block is sent in its negative-disparity form when the running disparity is negative. It is sent complemented when the disparity is positive and the form is unbalanced or x=7. Example: D7.0 gives 0x38B, and then 0x074.
- R5: The 4-bit sub-block uses the disparity left after the 6-bit sub-block. It is complemented when that disparity is positive and the form is unbalanced or y=3. Example: D0.3 gives 0x273 from negative and 0x18C from positive.
- R6: For y=7, the alternate 4-bit form (0111, or 1000 when complemented) replaces the primary one in two cases: x is 17, 18 or 20 and the disparity entering the 4-bit sub-block is negative, or x is 11, 13 or 14 and that disparity is positive. Example: D17.7 gives 0x237 from negative.
- R7: Each sub-block with unequal ones and zeros flips the running disparity. A balanced one leaves it unchanged.
- R8: With `ctrl_in` high, the twelve legal control bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE give their negative-disparity code when the disparity is negative, and its bitwise complement when it is positive. Example: 0xBC gives 0x0FA, or 0x305.
- R9: A balanced control code (0x1C, 0x9C, 0xFC, 0xF7, 0xFB, 0xFD, 0xFE) leaves the running disparity unchanged. The other control codes flip it.
- R10: With `ctrl_in` high, a byte that is not a legal control code yields the 0xBC control symbol with the correct polarity, and it updates the disparity as that symbol would.
- R11: Every symbol carries 4, 5 or 6 ones. A symbol sent after negative disparity never has fewer than 5 ones, and one sent after positive disparity never has more than 5.
- R12: No run of more than five equal bits appears within a symbol or across the boundary between consecutive symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in | input | 8 | Byte to encode, taken every cycle |
| ctrl_in | input | 1 | High: byte selects a control symbol; low: data symbol |
| sym_out | output | 10 | Encoded line symbol, bit 9 sent first |

## Verification
The alternate 4-bit choice and the running-disparity update both resolve in the final stage in the same cycle. The alternate form depends on a disparity that the preceding symbol and the current 6-bit sub-block have only just produced. The bench provokes this by sending D11.7 and D17.7 back to back and in both orders. Each therefore meets the polarity that the other one left behind, and it appears once on each side of the alternate rule. Every emitted symbol is compared against a value worked out by hand from the code tables. The join between each pair of consecutive symbols is also scanned for runs longer than five.

// File: rtl/enc8b10b_pkg.sv
// Package: shared widths, code tables and stage record for the 8B/10B encoder.
// Assumes: symbols are written {abcdei, fghj}, bit 9 = first line bit.
package enc8b10b_pkg;

    localparam int BYTE_W   = 8;
    localparam int SYM_W    = 10;
    localparam int SIX_W    = 6;
    localparam int FOUR_W   = 4;
    localparam int KSTORE_N = 12;
    localparam int KWORD_W  = SYM_W + 1;

    // Result of the lookup stage, consumed by the disparity stage.
    typedef struct packed {
        logic               is_ctrl;
        logic [SIX_W-1:0]   six;       // negative-disparity form
        logic               six_bal;   // three ones
        logic               six_flip;  // complement when disparity is positive
        logic [FOUR_W-1:0]  four;      // negative-disparity form, primary for y=7
        logic               y_is7;
        logic               y_is3;
        logic               alt_neg;   // x is 17, 18 or 20
        logic               alt_pos;   // x is 11, 13 or 14
        logic [KWORD_W-1:0] kword;     // {balanced, negative-disparity code}
    } look_t;

    // 5-bit to 6-bit code, negative-disparity form.
    function automatic logic [SIX_W-1:0] six_of(input logic [4:0] x);
        case (x)
            5'd0:  six_of = 6'b100111;  5'd1:  six_of = 6'b011101;
            5'd2:  six_of = 6'b101101;  5'd3:  six_of = 6'b110001;
            5'd4:  six_of = 6'b110101;  5'd5:  six_of = 6'b101001;
            5'd6:  six_of = 6'b011001;  5'd7:  six_of = 6'b111000;
            5'd8:  six_of = 6'b111001;  5'd9:  six_of = 6'b100101;
            5'd10: six_of = 6'b010101;  5'd11: six_of = 6'b110100;
            5'd12: six_of = 6'b001101;  5'd13: six_of = 6'b101100;
            5'd14: six_of = 6'b011100;  5'd15: six_of = 6'b010111;
            5'd16: six_of = 6'b011011;  5'd17: six_of = 6'b100011;
            5'd18: six_of = 6'b010011;  5'd19: six_of = 6'b110010;
            5'd20: six_of = 6'b001011;  5'd21: six_of = 6'b101010;
            5'd22: six_of = 6'b011010;  5'd23: six_of = 6'b111010;
            5'd24: six_of = 6'b110011;  5'd25: six_of = 6'b100110;
            5'd26: six_of = 6'b010110;  5'd27: six_of = 6'b110110;
            5'd28: six_of = 6'b001110;  5'd29: six_of = 6'b101110;
            5'd30: six_of = 6'b011110;  default: six_of = 6'b101011;
        endcase
    endfunction

    // 3-bit to 4-bit code, negative-disparity form (primary form for y=7).
    function automatic logic [FOUR_W-1:0] four_of(input logic [2:0] y);
        case (y)
            3'd0: four_of = 4'b1011;  3'd1: four_of = 4'b1001;
            3'd2: four_of = 4'b0101;  3'd3: four_of = 4'b1100;
            3'd4: four_of = 4'b1101;  3'd5: four_of = 4'b1010;
            3'd6: four_of = 4'b0110;  default: four_of = 4'b1110;
        endcase
    endfunction

    // Byte value of each control-store entry.
    function automatic logic [BYTE_W-1:0] kbyte_of(input int idx);
        case (idx)
            0: kbyte_of = 8'h1C;  1: kbyte_of = 8'h3C;  2: kbyte_of = 8'h5C;
            3: kbyte_of = 8'h7C;  4: kbyte_of = 8'h9C;  5: kbyte_of = 8'hBC;
            6: kbyte_of = 8'hDC;  7: kbyte_of = 8'hFC;  8: kbyte_of = 8'hF7;
            9: kbyte_of = 8'hFB; 10: kbyte_of = 8'hFD; default: kbyte_of = 8'hFE;
        endcase
    endfunction

    // Stored word of each control-store entry: {balanced, negative-disparity code}.
    function automatic logic [KWORD_W-1:0] kword_of(input int idx);
        case (idx)
            0: kword_of = {1'b1, 10'h0F4};  1: kword_of = {1'b0, 10'h0F9};
            2: kword_of = {1'b0, 10'h0F5};  3: kword_of = {1'b0, 10'h0F3};
            4: kword_of = {1'b1, 10'h0F2};  5: kword_of = {1'b0, 10'h0FA};
            6: kword_of = {1'b0, 10'h0F6};  7: kword_of = {1'b1, 10'h0F8};
            8: kword_of = {1'b1, 10'h3A8};  9: kword_of = {1'b1, 10'h368};
           10: kword_of = {1'b1, 10'h2E8}; default: kword_of = {1'b1, 10'h1E8};
        endcase
    endfunction

    // True when a 20-bit window holds six or more equal bits in a row.
    function automatic logic run_over5(input logic [2*SYM_W-1:0] w);
        run_over5 = 1'b0;
        for (int i = 0; i <= 2*SYM_W-6; i++) begin
            if (w[i +: 6] == 6'h3F || w[i +: 6] == 6'h00) run_over5 = 1'b1;
        end
    endfunction

endpackage

// File: rtl/enc_capture.sv
// Stage 1: registers the byte and control flag, and marks the stage valid
// from the first cycle after reset. Assumes synchronous active-low reset.
module enc_capture
    import enc8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ctrl_in,
    output logic [BYTE_W-1:0] cap_byte,
    output logic              cap_ctrl,
    output logic              cap_vld
);

    // Capture one input per cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_byte <= '0;
            cap_ctrl <= 1'b0;
            cap_vld  <= 1'b0;
        end else begin
            cap_byte <= byte_in;
            cap_ctrl <= ctrl_in;
            cap_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/enc_lookup.sv
// Stage 2: table lookups for the data sub-blocks and the twelve-entry control
// store, matched in parallel. A control byte that hits no entry takes the
// FALLBACK_IDX entry. Assumes the stored bytes are distinct.
module enc_lookup
    import enc8b10b_pkg::*;
#(
    parameter int FALLBACK_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              cap_ctrl,
    input  logic              cap_vld,
    output look_t             look_q,
    output logic              look_vld
);

    logic [KSTORE_N-1:0] hit;
    logic [KWORD_W-1:0]  kw;
    look_t               look_d;
    logic [4:0]          x_val;
    logic [2:0]          y_val;

    assign x_val = cap_byte[4:0];
    assign y_val = cap_byte[7:5];

    // One comparator per control-store entry.
    for (genvar gi = 0; gi < KSTORE_N; gi++) begin : g_kmatch
        assign hit[gi] = (cap_byte == kbyte_of(gi));
    end

    // Pick the matching control word, else the fallback entry.
    always_comb begin
        kw = kword_of(FALLBACK_IDX);
        for (int i = 0; i < KSTORE_N; i++) begin
            if (hit[i]) kw = kword_of(i);
        end
    end

    // Assemble the lookup record for the disparity stage.
    always_comb begin
        look_d.is_ctrl  = cap_ctrl;
        look_d.six      = six_of(x_val);
        look_d.six_bal  = ($countones(six_of(x_val)) == 3);
        look_d.six_flip = ($countones(six_of(x_val)) != 3) || (x_val == 5'd7);
        look_d.four     = four_of(y_val);
        look_d.y_is7    = (y_val == 3'd7);
        look_d.y_is3    = (y_val == 3'd3);
        look_d.alt_neg  = (x_val inside {5'd17, 5'd18, 5'd20});
        look_d.alt_pos  = (x_val inside {5'd11, 5'd13, 5'd14});
        look_d.kword    = kw;
    end

    // Register the lookup record and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_q   <= '0;
            look_vld <= 1'b0;
        end else begin
            look_q   <= look_d;
            look_vld <= cap_vld;
        end
    end

    // R9: the balanced flag of a selected control word matches its weight.
    p_kword_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_ctrl) |=>
        (look_q.kword[KWORD_W-1] == ($countones(look_q.kword[SYM_W-1:0]) == 5)));

endmodule

// File: rtl/enc_disparity.sv
// Stage 3: holds running disparity, picks sub-block polarity and the
// alternate 4-bit form, selects data or control, registers the symbol.
// Assumes disparity is negative after reset; output is 0 until valid.
module enc_disparity
    import enc8b10b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  look_t            look,
    input  logic             look_vld,
    output logic [SYM_W-1:0] sym_q
);

    localparam logic [FOUR_W-1:0] ALT7 = 4'b0111;

    logic              rd_q;      // 1 = positive running disparity
    logic              vld_q;
    logic              rd6;
    logic              use_alt;
    logic              four_bal;
    logic [SIX_W-1:0]  six_sel;
    logic [FOUR_W-1:0] four_m;
    logic [FOUR_W-1:0] four_sel;
    logic [SYM_W-1:0]  nxt_sym;
    logic              nxt_rd;

    // Resolve polarity of both sub-blocks and the control word.
    always_comb begin
        six_sel  = (rd_q && look.six_flip) ? ~look.six : look.six;
        rd6      = rd_q ^ !look.six_bal;
        use_alt  = look.y_is7 && (rd6 ? look.alt_pos : look.alt_neg);
        four_m   = use_alt ? ALT7 : look.four;
        four_bal = ($countones(four_m) == 2);
        four_sel = (rd6 && (!four_bal || look.y_is3)) ? ~four_m : four_m;
        if (look.is_ctrl) begin
            nxt_sym = rd_q ? ~look.kword[SYM_W-1:0] : look.kword[SYM_W-1:0];
            nxt_rd  = look.kword[KWORD_W-1] ? rd_q : !rd_q;
        end else begin
            nxt_sym = {six_sel, four_sel};
            nxt_rd  = rd6 ^ !four_bal;
        end
    end

    // Register symbol and disparity when the lookup stage holds a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
            rd_q  <= 1'b0;
            vld_q <= 1'b0;
        end else if (look_vld) begin
            sym_q <= nxt_sym;
            rd_q  <= nxt_rd;
            vld_q <= 1'b1;
        end
    end

    // R1: quiet output and negative disparity until the first symbol.
    p_fill_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> (sym_q == '0 && !rd_q));

    // R11: symbol weight stays within 4..6 ones.
    p_weight_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ($countones(sym_q) >= 4 && $countones(sym_q) <= 6));

    // R11: negative disparity is never followed by a light symbol.
    p_after_neg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (look_vld && !rd_q) |=> ($countones(sym_q) >= 5));

    // R11: positive disparity is never followed by a heavy symbol.
    p_after_pos_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (look_vld && rd_q) |=> ($countones(sym_q) <= 5));

    // R7: disparity flips exactly when the emitted symbol is unbalanced.
    p_rd_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        look_vld |=> (rd_q == ($past(rd_q) ^ ($countones(sym_q) != 5))));

    // R6: alternate form under negative disparity for x = 17, 18, 20.
    p_alt_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (look_vld && !look.is_ctrl && look.y_is7 && look.alt_neg && !rd_q)
        |=> (sym_q[FOUR_W-1:0] == 4'b0111));

    // R6: alternate form under positive disparity for x = 11, 13, 14.
    p_alt_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (look_vld && !look.is_ctrl && look.y_is7 && look.alt_pos && rd_q)
        |=> (sym_q[FOUR_W-1:0] == 4'b1000));

    // R12: no run above five across two consecutive symbols.
    p_run_limit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && $past(vld_q)) |-> !run_over5({$past(sym_q), sym_q}));

endmodule

// File: rtl/sym8b10b_encoder.sv
// Top: three-stage 8B/10B encoder (capture, lookup, disparity/output).
// Assumes one input per cycle from the first cycle after reset release.
module sym8b10b_encoder
    import enc8b10b_pkg::*;
#(
    parameter int FALLBACK_IDX = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  byte_in,
    input  logic        ctrl_in,
    output logic [9:0]  sym_out
);

    logic [BYTE_W-1:0] cap_byte;
    logic              cap_ctrl;
    logic              cap_vld;
    look_t             look_q;
    logic              look_vld;

    enc_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .ctrl_in  (ctrl_in),
        .cap_byte (cap_byte),
        .cap_ctrl (cap_ctrl),
        .cap_vld  (cap_vld)
    );

    enc_lookup #(.FALLBACK_IDX(FALLBACK_IDX)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_byte (cap_byte),
        .cap_ctrl (cap_ctrl),
        .cap_vld  (cap_vld),
        .look_q   (look_q),
        .look_vld (look_vld)
    );

    enc_disparity u_disparity (
        .clk      (clk),
        .rst_n    (rst_n),
        .look     (look_q),
        .look_vld (look_vld),
        .sym_q    (sym_out)
    );

endmodule

// File: tb/test_sym8b10b_encoder.sv
// Directed bench: one task per scenario; expected symbols worked out by hand.
module test_sym8b10b_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic       ctrl_in = 1'b0;
    logic [9:0] sym_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [9:0] exp_q [3];
    bit         chk_q [3];
    string      tag_q [3];
    logic [9:0] prev_out = '0;

    sym8b10b_encoder i_sym8b10b_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_in (byte_in),
        .ctrl_in (ctrl_in),
        .sym_out (sym_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit long_run(input logic [19:0] w);
        for (int i = 0; i <= 14; i++) begin
            if (w[i +: 6] == 6'h3F || w[i +: 6] == 6'h00) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%03h expected=0x%03h", tag, act, exp);
        end
    endtask

    // One cycle: check the output due now, then drive the next input.
    task automatic step(input logic [7:0] b, input logic k, input logic [9:0] exp,
                        input bit chk, input string tag);
        @(negedge clk);
        if (chk_q[2]) check(tag_q[2], sym_out, exp_q[2]);
        if (sym_out != '0 && prev_out != '0) begin
            n_checks++;
            if (long_run({prev_out, sym_out})) begin
                n_fail++;
                $display("FAIL R12: actual run>5 in 0x%03h,0x%03h expected run<=5",
                         prev_out, sym_out);
            end
        end
        prev_out = sym_out;
        exp_q[2] = exp_q[1]; chk_q[2] = chk_q[1]; tag_q[2] = tag_q[1];
        exp_q[1] = exp_q[0]; chk_q[1] = chk_q[0]; tag_q[1] = tag_q[0];
        exp_q[0] = exp;      chk_q[0] = chk;      tag_q[0] = tag;
        rst_n   = 1'b1;
        byte_in = b;
        ctrl_in = k;
    endtask

    // Push fillers until everything in flight has been checked.
    task automatic drain();
        for (int i = 0; i < 3; i++) step(8'hBC, 1'b1, '0, 1'b0, "drain");
    endtask

    // Hold reset, check quiet output, expect three quiet cycles after release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; byte_in = '0; ctrl_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", sym_out, 10'h000);
        prev_out = '0;
        for (int i = 0; i < 3; i++) begin
            exp_q[i] = '0; chk_q[i] = 1'b1; tag_q[i] = "R1 fill";
        end
    endtask

    task automatic t_reset();
        do_reset();
        step(8'h3C, 1'b1, 10'h0F9, 1'b1, "R2 first symbol after 3 cycles");
        step(8'h3C, 1'b1, 10'h306, 1'b1, "R8 K28.1 positive");
        step(8'h3C, 1'b1, 10'h0F9, 1'b1, "R8 K28.1 negative");
        drain();
        step(8'h3C, 1'b1, '0, 1'b0, "unchecked");   // leaves disparity positive
        do_reset();
        step(8'h3C, 1'b1, 10'h0F9, 1'b1, "R1 disparity negative after mid reset");
        drain();
    endtask

    task automatic t_data();
        do_reset();
        step(8'h00, 1'b0, 10'h274, 1'b1, "R3 D0.0");
        step(8'hB5, 1'b0, 10'h2AA, 1'b1, "R7 D21.5 balanced");
        step(8'h67, 1'b0, 10'h38C, 1'b1, "R5 D7.3 negative");
        step(8'h07, 1'b0, 10'h38B, 1'b1, "R4 D7.0 negative");
        step(8'h07, 1'b0, 10'h074, 1'b1, "R4 D7.0 positive");
        step(8'hAF, 1'b0, 10'h17A, 1'b1, "R4 D15.5 negative");
        step(8'hAF, 1'b0, 10'h28A, 1'b1, "R4 D15.5 positive");
        step(8'h60, 1'b0, 10'h273, 1'b1, "R5 D0.3 negative");
        step(8'h60, 1'b0, 10'h18C, 1'b1, "R5 D0.3 positive");
        step(8'h63, 1'b0, 10'h31C, 1'b1, "R7 D3.3 keeps disparity");
        drain();
    endtask

    task automatic t_alt7();
        do_reset();
        step(8'hF1, 1'b0, 10'h237, 1'b1, "R6 D17.7 alternate negative");
        step(8'hEB, 1'b0, 10'h348, 1'b1, "R6 D11.7 alternate positive");
        step(8'hEB, 1'b0, 10'h34E, 1'b1, "R6 D11.7 primary negative");
        step(8'hF1, 1'b0, 10'h231, 1'b1, "R6 D17.7 primary positive");
        step(8'hF4, 1'b0, 10'h0B7, 1'b1, "R6 D20.7 alternate");
        step(8'hED, 1'b0, 10'h2C8, 1'b1, "R6 D13.7 alternate");
        step(8'hF2, 1'b0, 10'h137, 1'b1, "R6 D18.7 alternate");
        step(8'hEE, 1'b0, 10'h1C8, 1'b1, "R6 D14.7 alternate");
        step(8'hE1, 1'b0, 10'h1D1, 1'b1, "R6 D1.7 primary complemented");
        drain();
    endtask

    task automatic t_kstore();
        do_reset();
        step(8'h1C, 1'b1, 10'h0F4, 1'b1, "R9 K28.0 balanced");
        step(8'h1C, 1'b1, 10'h0F4, 1'b1, "R9 K28.0 keeps disparity");
        step(8'h3C, 1'b1, 10'h0F9, 1'b1, "R8 K28.1");
        step(8'hFD, 1'b1, 10'h117, 1'b1, "R8 K29.7 positive");
        step(8'hFC, 1'b1, 10'h307, 1'b1, "R9 K28.7 positive");
        step(8'hBC, 1'b1, 10'h305, 1'b1, "R8 K28.5 positive");
        step(8'hF7, 1'b1, 10'h3A8, 1'b1, "R9 K23.7");
        step(8'hFB, 1'b1, 10'h368, 1'b1, "R9 K27.7");
        step(8'hFE, 1'b1, 10'h1E8, 1'b1, "R9 K30.7");
        step(8'h5C, 1'b1, 10'h0F5, 1'b1, "R8 K28.2");
        step(8'h7C, 1'b1, 10'h30C, 1'b1, "R8 K28.3 positive");
        step(8'h9C, 1'b1, 10'h0F2, 1'b1, "R9 K28.4");
        step(8'hDC, 1'b1, 10'h0F6, 1'b1, "R8 K28.6");
        drain();
    endtask

    task automatic t_illegal_k();
        do_reset();
        step(8'h00, 1'b1, 10'h0FA, 1'b1, "R10 0x00 as control");
        step(8'h55, 1'b1, 10'h305, 1'b1, "R10 0x55 as control");
        step(8'hFF, 1'b1, 10'h0FA, 1'b1, "R10 0xFF as control");
        step(8'hBC, 1'b0, 10'h0EA, 1'b1, "R3 0xBC as data D28.5");
        step(8'h7C, 1'b1, 10'h30C, 1'b1, "R10 legal K28.3 after");
        drain();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2: watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            exp_q[i] = '0; chk_q[i] = 1'b0; tag_q[i] = "";
        end
        t_reset();
        t_data();
        t_alt7();
        t_kstore();
        t_illegal_k();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule